// File: doc/BRIEF.md
# Duplicated Decoder with Dual-Rail Error Checking

This block wraps a 3-to-8 line decoder with concurrent error detection. It holds two independent copies of the decoding function. One copy produces the true one-hot outputs seen by the rest of the chip. The other copy computes the same function but presents every output inverted. Each true output is paired with its inverted partner. The resulting pairs feed a binary tree of two-rail checker cells. The tree reduces all the pairs to a single error pair (f, g).

When both copies agree, the error pair is a valid two-rail value: f and g differ. If any output of either copy goes wrong, the pair for that bit has equal rails. The tree then carries the error up to the top, and f equals g. A fault inside the tree itself also shows up at the top as a non-codeword. The decoder has an enable input. Over normal operation the error pair therefore takes both valid values, which exercises every part of the checker tree.

The block is purely combinational. For verification only, parameters can force one output of either copy to a fixed value, which models a single stuck-at fault.

Top module: `dup_decode_ced`

## Requirements
- R1: With the enable high, output `dec_o` has exactly bit `sel_i` set. With the enable low, `dec_o` is all zeros.
- R2: If a stuck-at fault makes any single output of either copy differ from its fault-free value, the error pair (`err_f_o`, `err_g_o`) reads 00 or 11 for that input.
- R3: With no fault present, the error pair always reads 01 or 10 (`err_f_o` differs from `err_g_o`).
- R4: In the default 8-output configuration with no fault, a disabled decoder gives `err_f_o`=1 and `err_g_o`=0, and an enabled decoder gives `err_f_o`=0 and `err_g_o`=1. Both valid error codewords therefore occur over the input space.
- R5: A stuck-at fault whose forced value equals the fault-free value of that bit leaves the error pair a valid codeword (01 or 10) and leaves `dec_o` correct.
- R6: A stuck-at fault on the inverted copy never alters `dec_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Decoder enable; when low, all outputs are zero |
| sel_i | input | SEL_W (3) | Index of the output to assert |
| dec_o | output | 2**SEL_W (8) | True one-hot decoder outputs from the first copy |
| err_f_o | output | 1 | First rail of the dual-rail error indication |
| err_g_o | output | 1 | Second rail of the dual-rail error indication |

## Verification
Nothing in this block holds state, so a wrong internal value shows up at the ports for the same input vector that exposes it. A stuck output on the true copy appears directly on `dec_o`. It also drives the error pair to equal rails on every input whose fault-free value for that bit differs from the stuck level. A stuck output on the inverted copy stays invisible on `dec_o` and is seen only on the error pair. Because the error pair settles to 10 when disabled and 01 when enabled, a checker cell stuck at either level cannot stay hidden over a sweep that covers both enable values.

// File: rtl/ced_pkg.sv
package ced_pkg;

   // Where a test-only stuck-at fault is placed
   typedef enum int {
      FLT_NONE = 0,
      FLT_TRUE = 1,
      FLT_CMP  = 2
   } flt_site_e;

   localparam int MAX_SEL_W = 6;

endpackage

// File: rtl/ced_dec_copy.sv
module ced_dec_copy #(
   parameter int SEL_W   = 3,
   parameter bit INVERT  = 1'b0,
   parameter bit FLT_ON  = 1'b0,
   parameter int FLT_BIT = 0,
   parameter bit FLT_VAL = 1'b0
) (
   input  logic                  en_i,
   input  logic [SEL_W-1:0]      sel_i,
   output logic [(1<<SEL_W)-1:0] y_o
);
   localparam int OUT_N = 1 << SEL_W;

   if (FLT_ON && (FLT_BIT < 0 || FLT_BIT >= OUT_N)) begin : g_bad_bit
      $error("ced_dec_copy: fault bit %0d outside 0..%0d", FLT_BIT, OUT_N-1);
   end

   logic [OUT_N-1:0] onehot;
   logic [OUT_N-1:0] shaped;

   always_comb begin
      onehot = '0;
      for (int i = 0; i < OUT_N; i++) begin
         onehot[i] = en_i && (sel_i == SEL_W'(i));
      end
   end

   if (INVERT) begin : g_inv
      assign shaped = ~onehot;
   end else begin : g_true
      assign shaped = onehot;
   end

   for (genvar b = 0; b < OUT_N; b++) begin : g_bit
      if (FLT_ON && b == FLT_BIT) begin : g_stuck
         assign y_o[b] = FLT_VAL;
      end else begin : g_pass
         assign y_o[b] = shaped[b];
      end
   end

endmodule

// File: rtl/ced_twr_cell.sv
module ced_twr_cell (
   input  logic a0_i,
   input  logic a1_i,
   input  logic b0_i,
   input  logic b1_i,
   output logic f_o,
   output logic g_o
);
   // Same-rail products form f, cross-rail products form g
   assign f_o = (a0_i & b0_i) | (a1_i & b1_i);
   assign g_o = (a0_i & b1_i) | (a1_i & b0_i);
endmodule

// File: rtl/ced_twr_tree.sv
module ced_twr_tree #(
   parameter int PAIRS = 8
) (
   input  logic [PAIRS-1:0] rail0_i,
   input  logic [PAIRS-1:0] rail1_i,
   output logic             f_o,
   output logic             g_o
);
   // Heap layout: leaves at PAIRS-1 .. 2*PAIRS-2, node k combines 2k+1 and 2k+2
   localparam int NODES = 2 * PAIRS - 1;
   localparam int FIRST_LEAF = PAIRS - 1;

   if (PAIRS < 1) begin : g_bad_pairs
      $error("ced_twr_tree: PAIRS must be at least 1");
   end

   logic [NODES-1:0] nf;
   logic [NODES-1:0] ng;

   for (genvar i = 0; i < PAIRS; i++) begin : g_leaf
      assign nf[FIRST_LEAF+i] = rail0_i[i];
      assign ng[FIRST_LEAF+i] = rail1_i[i];
   end

   for (genvar k = 0; k < FIRST_LEAF; k++) begin : g_node
      ced_twr_cell u_cell (
         .a0_i (nf[2*k+1]),
         .a1_i (ng[2*k+1]),
         .b0_i (nf[2*k+2]),
         .b1_i (ng[2*k+2]),
         .f_o  (nf[k]),
         .g_o  (ng[k])
      );
   end

   assign f_o = nf[0];
   assign g_o = ng[0];
endmodule

// File: rtl/dup_decode_ced.sv
module dup_decode_ced
   import ced_pkg::*;
#(
   parameter int        SEL_W    = 3,
   parameter flt_site_e FLT_SITE = FLT_NONE,
   parameter int        FLT_BIT  = 0,
   parameter bit        FLT_VAL  = 1'b0
) (
   input  logic                  en_i,
   input  logic [SEL_W-1:0]      sel_i,
   output logic [(1<<SEL_W)-1:0] dec_o,
   output logic                  err_f_o,
   output logic                  err_g_o
);
   localparam int OUT_N = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > MAX_SEL_W) begin : g_bad_width
      $error("dup_decode_ced: SEL_W %0d outside 1..%0d", SEL_W, MAX_SEL_W);
   end

   logic [OUT_N-1:0] dec_true;
   logic [OUT_N-1:0] dec_cmp;

   ced_dec_copy #(
      .SEL_W   (SEL_W),
      .INVERT  (1'b0),
      .FLT_ON  (FLT_SITE == FLT_TRUE),
      .FLT_BIT (FLT_BIT),
      .FLT_VAL (FLT_VAL)
   ) u_copy_true (
      .en_i  (en_i),
      .sel_i (sel_i),
      .y_o   (dec_true)
   );

   ced_dec_copy #(
      .SEL_W   (SEL_W),
      .INVERT  (1'b1),
      .FLT_ON  (FLT_SITE == FLT_CMP),
      .FLT_BIT (FLT_BIT),
      .FLT_VAL (FLT_VAL)
   ) u_copy_cmp (
      .en_i  (en_i),
      .sel_i (sel_i),
      .y_o   (dec_cmp)
   );

   ced_twr_tree #(
      .PAIRS (OUT_N)
   ) u_tree (
      .rail0_i (dec_true),
      .rail1_i (dec_cmp),
      .f_o     (err_f_o),
      .g_o     (err_g_o)
   );

   assign dec_o = dec_true;

endmodule

// File: rtl/dup_decode_ced_chk.sv
module dup_decode_ced_chk
   import ced_pkg::*;
#(
   parameter int        SEL_W    = 3,
   parameter flt_site_e FLT_SITE = FLT_NONE
) (
   input logic                  en_i,
   input logic [SEL_W-1:0]      sel_i,
   input logic [(1<<SEL_W)-1:0] dec_o,
   input logic [(1<<SEL_W)-1:0] dec_cmp,
   input logic                  err_f_o,
   input logic                  err_g_o
);
   localparam int OUT_N = 1 << SEL_W;

   always_comb begin
      if (FLT_SITE == FLT_NONE) begin
         AST_DEC_ONEHOT: assert (en_i ? ($onehot(dec_o) && dec_o[sel_i]) : (dec_o == '0)); // R1
         AST_ERR_CODEWORD: assert (err_f_o != err_g_o); // R3
         if (OUT_N == 8) begin
            AST_PAIR_BY_EN: assert ((err_f_o == !en_i) && (err_g_o == en_i)); // R4
         end
      end
      if (FLT_SITE == FLT_CMP) begin
         AST_TRUE_INTACT: assert (en_i ? ($onehot(dec_o) && dec_o[sel_i]) : (dec_o == '0)); // R6
      end
      if (dec_cmp != ~dec_o) begin
         AST_MISMATCH_FLAG: assert (err_f_o == err_g_o); // R2
      end else begin
         AST_MATCH_CLEAN: assert (err_f_o != err_g_o); // R5
      end
   end
endmodule

bind dup_decode_ced dup_decode_ced_chk #(
   .SEL_W    (SEL_W),
   .FLT_SITE (FLT_SITE)
) u_chk (
   .en_i    (en_i),
   .sel_i   (sel_i),
   .dec_o   (dec_o),
   .dec_cmp (dec_cmp),
   .err_f_o (err_f_o),
   .err_g_o (err_g_o)
);

// File: tb/dup_decode_ced_test.sv
`timescale 1ns/1ps
module dup_decode_ced_test;
   import ced_pkg::*;

   localparam int SEL_W = 3;
   localparam int OUT_N = 1 << SEL_W;
   localparam int NFLT  = 2 * OUT_N * 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             en;
   logic [SEL_W-1:0] sel;
   logic [OUT_N-1:0] dec;
   logic             ef, eg;

   int n_checks = 0;
   int n_fail   = 0;

   dup_decode_ced #(.SEL_W(SEL_W)) uut (
      .en_i (en), .sel_i (sel), .dec_o (dec), .err_f_o (ef), .err_g_o (eg)
   );

   // Faulted copies: index = site*16 + bit*2 + value
   logic [OUT_N-1:0] f_dec [NFLT];
   logic [NFLT-1:0]  f_ef;
   logic [NFLT-1:0]  f_eg;

   for (genvar c = 0; c < 2; c++) begin : g_site
      for (genvar b = 0; b < OUT_N; b++) begin : g_bit
         for (genvar v = 0; v < 2; v++) begin : g_val
            localparam int K = c*2*OUT_N + b*2 + v;
            dup_decode_ced #(
               .SEL_W    (SEL_W),
               .FLT_SITE (c == 0 ? FLT_TRUE : FLT_CMP),
               .FLT_BIT  (b),
               .FLT_VAL  (v[0])
            ) u_flt (
               .en_i (en), .sel_i (sel), .dec_o (f_dec[K]),
               .err_f_o (f_ef[K]), .err_g_o (f_eg[K])
            );
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [OUT_N-1:0] ref_dec(input logic e, input logic [SEL_W-1:0] s);
      return e ? (OUT_N'(1) << s) : '0;
   endfunction

   task automatic apply(input logic e, input logic [SEL_W-1:0] s);
      @(negedge clk);
      en  = e;
      sel = s;
      #1;
   endtask

   task automatic t_reset_state;
      apply(1'b0, '0);
      chk(dec == '0, "R1 idle outputs zero", 32'(dec), 0);
      chk({ef, eg} == 2'b10, "R4 idle error pair", 32'({ef, eg}), 32'h2);
   endtask

   task automatic t_decode_sweep;
      bit seen01 = 0;
      bit seen10 = 0;
      for (int e = 0; e < 2; e++) begin
         for (int s = 0; s < OUT_N; s++) begin
            apply(e[0], s[SEL_W-1:0]);
            chk(dec == ref_dec(e[0], s[SEL_W-1:0]), "R1 decode", 32'(dec), 32'(ref_dec(e[0], s[SEL_W-1:0])));
            chk(ef != eg, "R3 fault-free codeword", 32'({ef, eg}), 32'h1);
            chk({ef, eg} == (e[0] ? 2'b01 : 2'b10), "R4 pair by enable", 32'({ef, eg}), e[0] ? 32'h1 : 32'h2);
            if ({ef, eg} == 2'b01) seen01 = 1;
            if ({ef, eg} == 2'b10) seen10 = 1;
         end
      end
      chk(seen01 && seen10, "R4 both codewords seen", 32'({seen01, seen10}), 32'h3);
   endtask

   task automatic t_fault_sweep;
      for (int e = 0; e < 2; e++) begin
         for (int s = 0; s < OUT_N; s++) begin
            apply(e[0], s[SEL_W-1:0]);
            for (int c = 0; c < 2; c++) begin
               for (int b = 0; b < OUT_N; b++) begin
                  for (int v = 0; v < 2; v++) begin
                     automatic int k = c*2*OUT_N + b*2 + v;
                     automatic logic [OUT_N-1:0] good = ref_dec(e[0], s[SEL_W-1:0]);
                     automatic logic site_good = (c == 0) ? good[b] : ~good[b];
                     automatic logic [OUT_N-1:0] exp_dec = good;
                     if (c == 0) exp_dec[b] = v[0];
                     if (site_good != v[0]) begin
                        chk(f_ef[k] == f_eg[k], "R2 fault flagged", 32'({f_ef[k], f_eg[k]}), 32'h0);
                     end else begin
                        chk(f_ef[k] != f_eg[k], "R5 masked fault clean", 32'({f_ef[k], f_eg[k]}), 32'h1);
                        chk(f_dec[k] == good, "R5 masked fault output", 32'(f_dec[k]), 32'(good));
                     end
                     if (c == 1) begin
                        chk(f_dec[k] == good, "R6 true output intact", 32'(f_dec[k]), 32'(good));
                     end else begin
                        chk(f_dec[k] == exp_dec, "R2 stuck true bit visible", 32'(f_dec[k]), 32'(exp_dec));
                     end
                  end
               end
            end
         end
      end
   endtask

   bit done = 0;

   initial begin
      en  = 1'b0;
      sel = '0;
      t_reset_state();
      t_decode_sweep();
      t_fault_sweep();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule